// File: doc/BRIEF.md
# Replay-Capable Router Input Buffer

This block is the flit store that sits at one input port of a network router. Flits are written at a tail pointer and dequeued at a read head in arrival order, as in any FIFO. It also keeps a third pointer, the commit head. The commit head marks the oldest flit that has left the buffer but has not yet been confirmed as delivered intact by the error check at the switch output. Entries between the commit head and the read head stay in storage until they are confirmed.

Each output grant given to this input starts a fixed four-cycle delay. When that delay runs out, the commit head steps forward by one entry, and the freed slot is returned to the upstream sender as a one-cycle credit. A rollback command reloads the read head from the commit head, so every unconfirmed flit is dequeued again in its original order. Fullness is measured from the commit head rather than from the read head. As a result, an unconfirmed entry is never overwritten, and the upstream credit count stays consistent with what the buffer can still accept.

Top module: `rpf_replay_buffer`

## Requirements
- R1: After reset the buffer is empty, `rd_valid_o`, `full_o` and `credit_o` are low, and all three pointers are equal.
- R2: A write with `wr_en_i` high while `full_o` is low stores `wr_data_i` at the tail. `rd_data_o` always presents the oldest stored flit that has not yet been dequeued.
- R3: `rd_valid_o` is high exactly when at least one stored flit has not been dequeued. A dequeue (`rd_en_i` high while `rd_valid_o` is high) advances the read head by one. `rd_en_i` while `rd_valid_o` is low has no effect.
- R4: Suppose `grant_i` is sampled high at a clock edge. Then the commit head advances by one at the fourth clock edge after it, and `credit_o` is high for the single cycle that follows that fourth edge.
- R5: `full_o` is high when 8 entries lie between the commit head and the tail, whether or not they have been dequeued. A write while `full_o` is high is dropped, and the stored contents are left unchanged.
- R6: `rollback_i` sampled high loads the read head with the commit head. The flits after that point are then presented again, oldest first, followed by any flits never dequeued.
- R7: A rollback has three further effects. It discards every grant still inside the four-cycle delay, including a grant in the same cycle. It blocks a commit step due in that cycle. It ignores `rd_en_i` in that cycle. Writes in that cycle still obey R5.
- R8: A grant whose delay ends when the commit head equals the read head, meaning no flit is awaiting confirmation, is dropped and produces no credit.
- R9: The commit head never passes the read head, the read head never passes the tail, and the entry count never exceeds 8, including across pointer wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Flit write request |
| wr_data_i | input | 32 | Flit to store |
| rd_en_i | input | 1 | Dequeue request |
| rd_data_o | output | 32 | Oldest not-yet-dequeued flit |
| rd_valid_o | output | 1 | A flit is available to dequeue |
| grant_i | input | 1 | Output grant pulse for the flit just dequeued |
| rollback_i | input | 1 | Replay all unconfirmed flits |
| full_o | output | 1 | No free slot measured from the commit head |
| credit_o | output | 1 | One slot returned upstream |

## Verification
The hardest states to reach are the ones where a delayed grant is still travelling through the four-cycle line at the moment a rollback arrives. Also hard to reach is a full buffer whose entries have all been dequeued but none confirmed. The stimulus fills all eight slots and drains them with no grant, so that `full_o` must stay high. It then issues grants followed one cycle later by a rollback, so that credits that would otherwise appear must not. A long mixed phase then wraps the pointers many times, with rollbacks interleaved among writes, dequeues and grants. Each cycle is compared against a queue-based reference that holds the unconfirmed and the pending flits separately.

// File: rtl/rpf_pkg.sv
package rpf_pkg;

   // Number of entries from pointer b forward to pointer a, with wrap bit.
   function automatic int unsigned ptr_dist(input int unsigned a,
                                            input int unsigned b,
                                            input int unsigned ptr_w);
      int unsigned m;
      m = (32'd1 << ptr_w) - 1;
      return (a - b) & m;
   endfunction

   typedef struct packed {
      logic wr;
      logic rd;
      logic cmt;
   } rpf_evt_t;

endpackage

// File: rtl/rpf_ptr.sv
module rpf_ptr #(
   parameter int PTR_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             load,
   input  logic [PTR_W-1:0] load_val,
   output logic [PTR_W-1:0] ptr
);

   if (PTR_W < 2) begin : g_bad_w
      $error("rpf_ptr: PTR_W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr <= '0;
      else if (load)
         ptr <= load_val;
      else if (inc)
         ptr <= ptr + 1'b1;
   end

endmodule

// File: rtl/rpf_store.sv
module rpf_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 8,
   parameter int AW     = 3
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);

   if ((1 << AW) != DEPTH) begin : g_bad_aw
      $error("rpf_store: AW does not match DEPTH");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/rpf_grant_delay.sv
module rpf_grant_delay #(
   parameter int LAT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic pulse_in,
   output logic pulse_out
);

   if (LAT < 0) begin : g_bad_lat
      $error("rpf_grant_delay: LAT must not be negative");
   end

   if (LAT == 0) begin : g_bypass
      assign pulse_out = pulse_in & ~clr;
   end else begin : g_line
      logic [LAT-1:0] stage;
      for (genvar i = 0; i < LAT; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n || clr)
                  stage[0] <= 1'b0;
               else
                  stage[0] <= pulse_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n || clr)
                  stage[i] <= 1'b0;
               else
                  stage[i] <= stage[i-1];
            end
         end
      end
      assign pulse_out = stage[LAT-1];

      // R7
      clear_empties_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
         clr |=> (stage == '0));
   end

endmodule

// File: rtl/rpf_replay_buffer.sv
module rpf_replay_buffer #(
   parameter int DATA_W     = 32,
   parameter int DEPTH      = 8,
   parameter int COMMIT_LAT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              rd_en_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rd_valid_o,
   input  logic              grant_i,
   input  logic              rollback_i,
   output logic              full_o,
   output logic              credit_o
);

   import rpf_pkg::*;

   localparam int AW    = $clog2(DEPTH);
   localparam int PTR_W = AW + 1;
   localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rpf_replay_buffer: DEPTH must be a power of two, at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("rpf_replay_buffer: DATA_W must be positive");
   end

   logic [PTR_W-1:0] tail_ptr, rd_ptr, cmt_ptr;
   logic [PTR_W-1:0] occ_all, occ_unv;
   logic             grant_due;
   rpf_evt_t         evt;

   assign occ_all    = tail_ptr - cmt_ptr;
   assign occ_unv    = rd_ptr - cmt_ptr;
   assign full_o     = (occ_all == DEPTH_P);
   assign rd_valid_o = (rd_ptr != tail_ptr);

   assign evt.wr  = wr_en_i & ~full_o;
   assign evt.rd  = rd_en_i & rd_valid_o & ~rollback_i;
   assign evt.cmt = grant_due & (cmt_ptr != rd_ptr) & ~rollback_i;

   rpf_ptr #(.PTR_W(PTR_W)) u_tail (
      .clk(clk), .rst_n(rst_n), .inc(evt.wr), .load(1'b0),
      .load_val('0), .ptr(tail_ptr));

   rpf_ptr #(.PTR_W(PTR_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .inc(evt.rd), .load(rollback_i),
      .load_val(cmt_ptr), .ptr(rd_ptr));

   rpf_ptr #(.PTR_W(PTR_W)) u_cmt (
      .clk(clk), .rst_n(rst_n), .inc(evt.cmt), .load(1'b0),
      .load_val('0), .ptr(cmt_ptr));

   rpf_grant_delay #(.LAT(COMMIT_LAT)) u_dly (
      .clk(clk), .rst_n(rst_n), .clr(rollback_i),
      .pulse_in(grant_i), .pulse_out(grant_due));

   rpf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
      .clk(clk), .we(evt.wr), .waddr(tail_ptr[AW-1:0]), .wdata(wr_data_i),
      .raddr(rd_ptr[AW-1:0]), .rdata(rd_data_o));

   always_ff @(posedge clk) begin
      if (!rst_n)
         credit_o <= 1'b0;
      else
         credit_o <= evt.cmt;
   end

   // R9
   fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_dist(32'(tail_ptr), 32'(cmt_ptr), PTR_W) <= DEPTH);

   // R9
   ptr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      occ_unv <= occ_all);

   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && wr_en_i) |=> $stable(tail_ptr));

   // R6
   rollback_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rollback_i |=> (rd_ptr == $past(cmt_ptr)));

   // R4
   credit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      credit_o |-> (cmt_ptr == $past(cmt_ptr) + 1'b1));

   // R3
   empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_valid_o && !rollback_i) |=> $stable(rd_ptr));

endmodule

// File: tb/rpf_replay_buffer_test.sv
module rpf_replay_buffer_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0, grant = 1'b0, rollback = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        rd_valid, full, credit;

   int compared = 0;
   int mismatched = 0;
   string cur_req = "R1";

   logic [31:0] pend[$];
   logic [31:0] unver[$];
   logic [3:0]  dly_m = '0;
   logic        cred_exp = 1'b0;
   logic [31:0] next_val = 32'hA000_0000;

   always #10 clk = ~clk;

   rpf_replay_buffer uut (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
      .rd_en_i(rd_en), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
      .grant_i(grant), .rollback_i(rollback), .full_o(full), .credit_o(credit));

   task automatic chk(input bit ok, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
      end
   endtask

   // Monitor side: compare outputs against the scoreboard queues.
   task automatic monitor();
      int total;
      total = pend.size() + unver.size();
      chk(rd_valid === (pend.size() > 0), "rd_valid", 32'(rd_valid), 32'(pend.size() > 0));
      chk(full === (total == 8), "full", 32'(full), 32'(total == 8));
      chk(credit === cred_exp, "credit", 32'(credit), 32'(cred_exp));
      if (pend.size() > 0)
         chk(rd_data === pend[0], "rd_data", rd_data, pend[0]);
   endtask

   // Driver side: apply one cycle of stimulus and advance the reference.
   task automatic step(input bit w, input bit r, input bit g, input bit rb);
      bit full_m, cmt_ev;
      @(negedge clk);
      monitor();
      wr_en = w; rd_en = r; grant = g; rollback = rb;
      wr_data = next_val;
      full_m = (pend.size() + unver.size()) == 8;
      cmt_ev = dly_m[3] && unver.size() > 0 && !rb;
      if (rb) begin
         pend = {unver, pend};
         unver.delete();
         dly_m = '0;
      end else begin
         if (cmt_ev) void'(unver.pop_front());
         if (r && pend.size() > 0) unver.push_back(pend.pop_front());
         dly_m = {dly_m[2:0], g};
      end
      if (w && !full_m) pend.push_back(next_val);
      if (w) next_val = next_val + 32'h0001_0011;
      cred_exp = cmt_ev;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      cur_req = "R1";
      idle(2);

      cur_req = "R2";
      for (int i = 0; i < 3; i++) step(1, 0, 0, 0);
      idle(1);

      cur_req = "R3";
      for (int i = 0; i < 4; i++) step(0, 1, 0, 0);   // last read on empty buffer
      idle(1);
      step(1, 0, 0, 0);
      step(0, 1, 0, 0);
      idle(1);

      cur_req = "R4";
      step(0, 0, 1, 0);
      step(0, 0, 1, 0);
      idle(2);
      step(0, 0, 1, 0);
      step(0, 0, 1, 0);
      idle(6);

      cur_req = "R8";
      step(0, 0, 1, 0);
      step(0, 0, 1, 0);
      idle(6);

      cur_req = "R5";
      for (int i = 0; i < 9; i++) step(1, 0, 0, 0);    // ninth write dropped
      for (int i = 0; i < 8; i++) step(0, 1, 0, 0);
      step(1, 0, 0, 0);                               // still full after draining
      idle(2);
      step(0, 0, 1, 0);
      step(0, 0, 1, 0);
      idle(6);
      step(1, 0, 0, 0);
      idle(1);

      cur_req = "R6";
      step(0, 0, 0, 1);
      for (int i = 0; i < 8; i++) step(0, 1, 0, 0);
      idle(1);

      cur_req = "R7";
      step(0, 0, 1, 0);
      step(0, 0, 1, 0);
      step(0, 1, 1, 1);                               // grant and read in rollback cycle
      idle(6);
      step(0, 1, 1, 0);
      idle(3);
      step(1, 0, 0, 1);                               // delayed grant due now is dropped
      idle(3);

      cur_req = "R9";
      for (int i = 0; i < 600; i++) begin
         int u;
         u = $urandom;
         step(u[0] | u[1], u[2] | u[3], u[4] & u[5] | u[6], (u[11:7] == 5'd3));
      end
      for (int i = 0; i < 12; i++) step(0, 1, 1, 0);
      idle(8);

      summary();
      $finish;
   end

endmodule